// File: doc/BRIEF.md
# Priority Bus Arbiter with Operand Locking

This block decides which of four masters drives a shared system bus: an external bus request, two DMA channels and the CPU. The grant goes to the highest-priority active requester. The block never takes the bus from an owner that is still inside an indivisible sequence. Such a sequence is either a multi-cycle operand or the read half of a read-modify-write pair.

The current owner reports three status flags every cycle. `cycle_end` marks the last clock of a bus cycle. `op_last` marks that this cycle completes the current operand. `rmw_read` marks that this cycle is the read of a locked read-modify-write. An operand boundary is a cycle in which `cycle_end` and `op_last` are high and `rmw_read` is low. The grant may move only on the clock edge that ends a boundary cycle, or at any edge while the owner is not requesting.

Requests are registered once before they take part in arbitration. A request must therefore already be present in the cycle before the boundary cycle. The priority between the two DMA channels follows their programmable levels.

Top module: `prio_bus_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no request, all grant bits and `bus_busy` are low.
- R2: Grant bit 0 is the external requester, bit 1 is DMA channel A, bit 2 is DMA channel B and bit 3 is the CPU. When the bus is free to change owner, the external request wins over any DMA channel, and any DMA channel wins over the CPU.
- R3: When both DMA channels compete and neither the external request nor another rule decides, the channel with the numerically larger level wins. Equal levels give the bus to channel A.
- R4: While the owner's sampled request is high, the grant does not change at the end of any cycle in which `cycle_end` is low or `op_last` is low, so a multi-cycle operand keeps the bus through all of its cycles.
- R5: While the owner's sampled request is high, a cycle with `rmw_read` high never ends with a grant change, even when `cycle_end` and `op_last` are high.
- R6: Requests are sampled by one register stage. A request that first appears in the boundary cycle itself does not take the bus at that boundary. A request present one cycle earlier does take it.
- R7: When no sampled request is active, the last grant is held (parked).
- R8: When the owner's sampled request is low, the owner counts as idle. The grant then passes at the next clock edge to the highest-priority active requester, whatever the status flags are.
- R9: At most one grant bit is high in any cycle.
- R10: `bus_busy` is high exactly when the granted requester's sampled request is high.
- R11: Every operand boundary is a preemption point. This includes the end of the read half of a dual-address DMA transfer and the end of each operand of a multi-operand operation. The new owner is granted on the edge that ends that boundary cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_req | input | 1 | External bus request |
| dma_a_req | input | 1 | DMA channel A request |
| dma_b_req | input | 1 | DMA channel B request |
| cpu_req | input | 1 | CPU request |
| dma_a_level | input | LVL_W | Priority level of DMA channel A |
| dma_b_level | input | LVL_W | Priority level of DMA channel B |
| cycle_end | input | 1 | Owner: this clock ends a bus cycle |
| op_last | input | 1 | Owner: this cycle completes the operand |
| rmw_read | input | 1 | Owner: this cycle is the read of a read-modify-write |
| grant | output | 4 | One-hot grant: bit0 external, bit1 DMA A, bit2 DMA B, bit3 CPU |
| bus_busy | output | 1 | Granted requester is actively requesting |

## Verification
Two functions can fall in the same cycle. A higher-priority request can become visible in exactly the cycle in which the owner signals an operand boundary, and a boundary-shaped cycle can be flagged as a read-modify-write read. The bench drives the new request together with the boundary flags to provoke the first case, and raises `rmw_read` together with `cycle_end` and `op_last` to provoke the second. In both cases the grant must stay with the old owner. The grant must move only on the first clean boundary afterwards, and the bench checks it on that exact edge. An exhaustive sweep over all request patterns and a grid of DMA levels compares each grant against an arithmetic model.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_EXT   = 2'd0,
    SRC_DMA_A = 2'd1,
    SRC_DMA_B = 2'd2,
    SRC_CPU   = 2'd3
  } src_e;
endpackage

// File: rtl/arb_reset_sync.sv
module arb_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/arb_req_sample.sv
module arb_req_sample #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] req_raw,
  output logic [WIDTH-1:0] req_q
);
  logic [WIDTH-1:0] req_d;

  always_comb begin
    req_d = req_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= req_d;
  end
endmodule

// File: rtl/arb_dma_rank.sv
module arb_dma_rank #(
  parameter int LVL_W = 3
) (
  input  logic [LVL_W-1:0] lvl_a,
  input  logic [LVL_W-1:0] lvl_b,
  output logic             a_first
);
  // ties resolve toward channel A
  always_comb begin
    a_first = (lvl_a >= lvl_b);
  end
endmodule

// File: rtl/arb_winner_pick.sv
module arb_winner_pick
  import arb_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_q,
  input  logic               a_first,
  output logic               any_req,
  output logic [NUM_SRC-1:0] win_oh
);
  logic [SRC_W-1:0] order [NUM_SRC];

  always_comb begin
    order[0] = SRC_EXT;
    order[1] = a_first ? SRC_DMA_A : SRC_DMA_B;
    order[2] = a_first ? SRC_DMA_B : SRC_DMA_A;
    order[3] = SRC_CPU;
  end

  always_comb begin
    win_oh  = '0;
    any_req = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!any_req && req_q[order[i]]) begin
        win_oh[order[i]] = 1'b1;
        any_req          = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter
  import arb_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_req,
  input  logic               dma_a_req,
  input  logic               dma_b_req,
  input  logic               cpu_req,
  input  logic [LVL_W-1:0]   dma_a_level,
  input  logic [LVL_W-1:0]   dma_b_level,
  input  logic               cycle_end,
  input  logic               op_last,
  input  logic               rmw_read,
  output logic [NUM_SRC-1:0] grant,
  output logic               bus_busy
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] req_raw;
  logic [NUM_SRC-1:0] req_q;
  logic               a_first;
  logic               any_req;
  logic [NUM_SRC-1:0] win_oh;
  logic [NUM_SRC-1:0] grant_q;
  logic [NUM_SRC-1:0] grant_d;
  logic               grant_en;
  logic               owner_active;
  logic               boundary;
  logic               window;

  arb_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    req_raw            = '0;
    req_raw[SRC_EXT]   = ext_req;
    req_raw[SRC_DMA_A] = dma_a_req;
    req_raw[SRC_DMA_B] = dma_b_req;
    req_raw[SRC_CPU]   = cpu_req;
  end

  arb_req_sample #(.WIDTH(NUM_SRC)) u_samp (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_raw (req_raw),
    .req_q   (req_q)
  );

  arb_dma_rank #(.LVL_W(LVL_W)) u_rank (
    .lvl_a   (dma_a_level),
    .lvl_b   (dma_b_level),
    .a_first (a_first)
  );

  arb_winner_pick u_pick (
    .req_q   (req_q),
    .a_first (a_first),
    .any_req (any_req),
    .win_oh  (win_oh)
  );

  // next-state: an idle owner or a clean operand boundary opens the window
  always_comb begin
    owner_active = |(grant_q & req_q);
    boundary     = cycle_end & op_last & ~rmw_read;
    window       = ~owner_active | boundary;
    grant_en     = window & any_req;
    grant_d      = win_oh;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   grant_q <= '0;
    else if (grant_en) grant_q <= grant_d;
  end

  assign grant    = grant_q;
  assign bus_busy = owner_active;
endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] grant,
  input logic [NUM_SRC-1:0] req_q,
  input logic               cycle_end,
  input logic               op_last,
  input logic               rmw_read,
  input logic               bus_busy
);
  assert_onehot_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_hold_midop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(grant & req_q)) && (!cycle_end || !op_last)) |=> $stable(grant));

  assert_rmw_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(grant & req_q)) && rmw_read) |=> $stable(grant));

  assert_park_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0) |=> $stable(grant));

  assert_ext_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q[0] && (!(|(grant & req_q)) || (cycle_end && op_last && !rmw_read)))
      |=> (grant == 4'b0001));

  assert_busy_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> (grant != '0));
endmodule

bind prio_bus_arbiter arb_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .grant     (grant),
  .req_q     (req_q),
  .cycle_end (cycle_end),
  .op_last   (op_last),
  .rmw_read  (rmw_read),
  .bus_busy  (bus_busy)
);

// File: tb/prio_bus_arbiter_test.sv
`timescale 1ns/1ps
module prio_bus_arbiter_test;
  localparam int LVL_W = 3;
  localparam logic [3:0] G_EXT = 4'b0001;
  localparam logic [3:0] G_A   = 4'b0010;
  localparam logic [3:0] G_B   = 4'b0100;
  localparam logic [3:0] G_CPU = 4'b1000;

  logic clk;
  logic rst_n;
  logic ext_req, dma_a_req, dma_b_req, cpu_req;
  logic [LVL_W-1:0] dma_a_level, dma_b_level;
  logic cycle_end, op_last, rmw_read;
  logic [3:0] grant;
  logic bus_busy;

  int checks;
  int errors;
  bit done;

  prio_bus_arbiter #(.LVL_W(LVL_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .ext_req(ext_req), .dma_a_req(dma_a_req), .dma_b_req(dma_b_req), .cpu_req(cpu_req),
    .dma_a_level(dma_a_level), .dma_b_level(dma_b_level),
    .cycle_end(cycle_end), .op_last(op_last), .rmw_read(rmw_read),
    .grant(grant), .bus_busy(bus_busy)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check_vec(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic e, input logic a, input logic b, input logic c);
    ext_req = e; dma_a_req = a; dma_b_req = b; cpu_req = c;
  endtask

  task automatic set_flags(input logic ce, input logic ol, input logic rm);
    cycle_end = ce; op_last = ol; rmw_read = rm;
  endtask

  // advance n rising edges, end on a falling edge
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] model(input logic [3:0] r, input int la, input int lb,
                                       input logic [3:0] prev);
    if (r == 4'b0)          return prev;
    if (r[0])               return G_EXT;
    if (r[1] && r[2])       return (la >= lb) ? G_A : G_B;
    if (r[1])               return G_A;
    if (r[2])               return G_B;
    return G_CPU;
  endfunction

  initial begin : watchdog
    int cyc;
    cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [3:0] exp_g;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0;
    set_req(0, 0, 0, 0);
    set_flags(0, 0, 0);
    dma_a_level = '0; dma_b_level = '0;
    #1;
    check_vec("R1 grant in reset", grant, 4'b0);
    check_bit("R1 busy in reset", bus_busy, 1'b0);
    tick(3);
    rst_n = 1'b1;
    tick(5);
    check_vec("R1 grant after release", grant, 4'b0);
    check_bit("R1 busy after release", bus_busy, 1'b0);

    // exhaustive sweep with window always open: R2 R3 R7 R10
    set_flags(1, 1, 0);
    exp_g = 4'b0;
    for (int la = 0; la < 4; la++) begin
      for (int lb = 0; lb < 4; lb++) begin
        for (int r = 0; r < 16; r++) begin
          logic [3:0] rv;
          rv = r[3:0];
          dma_a_level = la[LVL_W-1:0];
          dma_b_level = lb[LVL_W-1:0];
          set_req(rv[0], rv[1], rv[2], rv[3]);
          tick(2);
          exp_g = model(rv, la, lb, exp_g);
          check_vec($sformatf("R2 R3 R7 sweep req=%b la=%0d lb=%0d", rv, la, lb), grant, exp_g);
          check_bit($sformatf("R10 busy req=%b", rv), bus_busy, rv != 4'b0);
        end
      end
    end

    // R4 / R5 / R11: CPU owns, external waits for a clean boundary
    dma_a_level = 3'd0; dma_b_level = 3'd0;
    set_req(0, 0, 0, 1);
    tick(2);
    check_vec("R2 cpu alone", grant, G_CPU);
    set_flags(1, 0, 0);
    ext_req = 1'b1;
    tick(4);
    check_vec("R4 mid-operand cycles hold cpu", grant, G_CPU);
    set_flags(0, 1, 0);
    tick(2);
    check_vec("R4 no cycle end holds cpu", grant, G_CPU);
    set_flags(1, 1, 1);
    tick(3);
    check_vec("R5 rmw read holds cpu", grant, G_CPU);
    set_flags(1, 1, 0);
    tick(1);
    check_vec("R11 boundary hands to ext on next edge", grant, G_EXT);

    // R6: request appearing in the boundary cycle itself
    set_req(0, 0, 0, 1);
    tick(2);
    check_vec("R6 setup cpu", grant, G_CPU);
    set_flags(0, 0, 0);
    tick(1);
    ext_req = 1'b1;
    set_flags(1, 1, 0);
    tick(1);
    check_vec("R6 late request not taken", grant, G_CPU);
    set_flags(0, 0, 0);
    tick(2);
    check_vec("R6 held between boundaries", grant, G_CPU);
    set_flags(1, 1, 0);
    tick(1);
    check_vec("R6 earlier request taken", grant, G_EXT);

    // R8: owner drops request, no boundary flags
    set_flags(0, 0, 0);
    set_req(0, 1, 0, 1);
    tick(2);
    check_vec("R8 idle owner passes to dma A", grant, G_A);
    check_bit("R10 busy with dma A", bus_busy, 1'b1);

    // R11 + R3: read half of dual-address transfer is a preemption point
    dma_a_level = 3'd1; dma_b_level = 3'd3;
    dma_b_req = 1'b1;
    tick(3);
    check_vec("R4 dma A keeps bus mid-operand", grant, G_A);
    set_flags(1, 1, 0);
    tick(1);
    check_vec("R11 R3 higher level B at read-half end", grant, G_B);

    // R7 park
    set_req(0, 0, 0, 0);
    tick(3);
    check_vec("R7 parked on B", grant, G_B);
    check_bit("R10 parked not busy", bus_busy, 1'b0);

    // R1 reset mid-run
    rst_n = 1'b0;
    #1;
    check_vec("R1 grant cleared by reset", grant, 4'b0);
    check_bit("R1 busy cleared by reset", bus_busy, 1'b0);
    tick(2);
    rst_n = 1'b1;
    tick(4);
    check_vec("R1 grant after second release", grant, 4'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule